// File: doc/BRIEF.md
# Event Counter Bank with Coprocessor Register Reads

This block keeps ten free-running event counters for a processor core and lets software read them back through a coprocessor register-move read request. Each cycle the pipeline and caches may raise any mix of single-cycle event pulses. Every pulse adds one to its own counter, and all counters advance independently on the same clock.

A read request carries a coprocessor opcode and a register index. When the opcode equals the performance selector value 7 and the index names one of the ten counters, the block returns that counter's value one cycle later with a valid strobe. Any other opcode or index returns zero with the same strobe. A synchronous clear zeroes the whole bank. The asynchronous active-low reset is released synchronously inside the block, so counting and reads start two clock edges after `rst_n` rises.

Top module: `perf_ctr_bank`

## Requirements
- R1: Once reset has been released, `rd_valid_o` is low and every counter reads zero.
- R2: A read with `rd_op_i` = 7 and `rd_idx_i` = k for k from 0 to 9 returns counter k. Bit k of `evt_i` feeds counter k, and the counters are mapped as 0 retired instructions, 1 cycles, 2 instruction-cache misses, 3 data-cache misses, 4 instruction-side accesses, 5 data-side accesses, 6 predicted branches, 7 correctly predicted branches, 8 instruction aborts and 9 data aborts.
- R3: `rd_valid_o` is high in exactly the cycle after each cycle in which `rd_req_i` is high, and `rd_data_o` carries the result in that cycle. Back-to-back requests give back-to-back results.
- R4: Each counter adds one in every cycle its event bit is high, and counters do not affect one another.
- R5: A counter that holds its maximum value (all ones over `CNT_W` bits) wraps to zero on its next event.
- R6: A read with any opcode other than 7 returns zero.
- R7: A read with opcode 7 and an index from 10 to 15 returns zero.
- R8: A read made in the same cycle as an event on the selected counter returns the value from before that increment.
- R9: When `clr_i` is high, every counter is zero in the following cycle.
- R10: If `clr_i` and an event bit are both high in the same cycle, the counter still becomes zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr_i | input | 1 | Synchronous clear of all counters |
| evt_i | input | 10 | One event pulse per counter, bit k feeds counter k |
| rd_req_i | input | 1 | Read request strobe |
| rd_op_i | input | 3 | Coprocessor opcode of the read, 7 selects the counters |
| rd_idx_i | input | 4 | Coprocessor register index of the read |
| rd_valid_o | output | 1 | Read result valid, one cycle after the request |
| rd_data_o | output | CNT_W (32) | Read result |

## Verification
Two pairs of functions can fall in the same cycle. A read can coincide with an event on the counter it selects, and a clear can coincide with events. The bench provokes the first by pulsing the event bit in the cycle of the request, and it expects the pre-increment value followed by the incremented value on a second read. It provokes the second by raising every event bit together with the clear, and it then expects zero on all ten counters. A second instance with narrow counters is driven in parallel so that the wrap to zero can be reached in a short run.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  // Number of architectural event counters and read selector encoding
  localparam int NUM_EVT  = 10;
  localparam int OP_W     = 3;
  localparam int IDX_W    = 4;
  localparam logic [OP_W-1:0] PERF_OPCODE = 3'd7;
  localparam int DEF_CNT_W = 32;

  // Counter slot assignment; bit k of the event vector feeds slot k
  typedef enum logic [IDX_W-1:0] {
    EV_RETIRED   = 4'd0,
    EV_CYCLE     = 4'd1,
    EV_IC_MISS   = 4'd2,
    EV_DC_MISS   = 4'd3,
    EV_I_ACCESS  = 4'd4,
    EV_D_ACCESS  = 4'd5,
    EV_BR_PRED   = 4'd6,
    EV_BR_HIT    = 4'd7,
    EV_I_ABORT   = 4'd8,
    EV_D_ABORT   = 4'd9
  } perf_evt_e;

endpackage

// File: rtl/perf_rst_sync.sv
module perf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/perf_ctr_cell.sv
module perf_ctr_cell #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Clear wins over the event; the add wraps naturally at CNT_W bits
  always_comb begin
    cnt_en = clr | evt;
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R9 and R10: a clear leaves zero whatever the event does
  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  // R4 and R5: one step per event, wrapping at full scale
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R4: no event, no change
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(cnt));

endmodule

// File: rtl/perf_ctr_rdmux.sv
module perf_ctr_rdmux
  import perf_ctr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_EVT-1:0][CNT_W-1:0]  cnt,
  input  logic                           rd_req,
  input  logic [OP_W-1:0]                rd_op,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic                           rd_valid,
  output logic [CNT_W-1:0]               rd_data
);

  logic             hit;
  logic [CNT_W-1:0] sel;
  logic             valid_q;
  logic [CNT_W-1:0] data_q;
  logic [CNT_W-1:0] data_d;

  // Decode: only the performance opcode with an in-range index selects
  always_comb begin
    hit = (rd_op == PERF_OPCODE);
    sel = '0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (hit && (rd_idx == IDX_W'(k))) begin
        sel = cnt[k];
      end
    end
    data_d = sel;
  end

  // Sampling the counters before their update gives pre-increment data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (rd_req) begin
      data_q <= data_d;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  // R3: one result per request, in the next cycle
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  // R6: foreign opcode reads zero
  assert_foreign_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_op != PERF_OPCODE) |=> (rd_data == '0));

  // R7: index past the last counter reads zero
  assert_high_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_idx >= IDX_W'(NUM_EVT)) |=> (rd_data == '0));

  // R2 and R8: in-range read returns the selected counter as it stood
  assert_selected_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_op == PERF_OPCODE && rd_idx == IDX_W'(0)) |=> (rd_data == $past(cnt[0])));

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_ctr_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic [NUM_EVT-1:0]  evt_i,
  input  logic                rd_req_i,
  input  logic [OP_W-1:0]     rd_op_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic                rd_valid_o,
  output logic [CNT_W-1:0]    rd_data_o
);

  logic                          rst_int_n;
  logic [NUM_EVT-1:0][CNT_W-1:0] cnt_bus;

  perf_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cell
    perf_ctr_cell #(
      .CNT_W (CNT_W)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (clr_i),
      .evt   (evt_i[g]),
      .cnt   (cnt_bus[g])
    );
  end

  perf_ctr_rdmux #(
    .CNT_W (CNT_W)
  ) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cnt      (cnt_bus),
    .rd_req   (rd_req_i),
    .rd_op    (rd_op_i),
    .rd_idx   (rd_idx_i),
    .rd_valid (rd_valid_o),
    .rd_data  (rd_data_o)
  );

  // R1: nothing is reported while the bank is held in reset
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_int_n |=> !rd_valid_o);

endmodule

// File: tb/test_perf_ctr_bank.sv
module test_perf_ctr_bank;

  localparam int NW = 6;  // narrow instance width for the wrap test

  logic        clk;
  logic        rst_n;
  logic        clr_i;
  logic [9:0]  evt_i;
  logic        rd_req_i;
  logic [2:0]  rd_op_i;
  logic [3:0]  rd_idx_i;
  logic        rd_valid_o;
  logic [31:0] rd_data_o;
  logic        nrw_valid;
  logic [NW-1:0] nrw_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] mdl [10];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  perf_ctr_bank i_perf_ctr_bank (
    .clk (clk), .rst_n (rst_n), .clr_i (clr_i), .evt_i (evt_i),
    .rd_req_i (rd_req_i), .rd_op_i (rd_op_i), .rd_idx_i (rd_idx_i),
    .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o)
  );

  perf_ctr_bank #(.CNT_W (NW)) i_perf_ctr_bank_narrow (
    .clk (clk), .rst_n (rst_n), .clr_i (clr_i), .evt_i (evt_i),
    .rd_req_i (rd_req_i), .rd_op_i (rd_op_i), .rd_idx_i (rd_idx_i),
    .rd_valid_o (nrw_valid), .rd_data_o (nrw_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  // Driver: one cycle of stimulus; expected read pushed before model update
  task automatic step(input logic [9:0] evt, input logic clr, input logic req,
                      input logic [2:0] op, input logic [3:0] idx, input string tag);
    @(negedge clk);
    evt_i = evt; clr_i = clr; rd_req_i = req; rd_op_i = op; rd_idx_i = idx;
    if (req) begin
      exp_q.push_back((op == 3'd7 && idx <= 4'd9) ? mdl[idx] : 32'd0);
      tag_q.push_back(tag);
    end
    for (int k = 0; k < 10; k++) begin
      if (clr) mdl[k] = 32'd0;
      else if (evt[k]) mdl[k] = mdl[k] + 32'd1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(10'd0, 1'b0, 1'b0, 3'd0, 4'd0, "");
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 10; k++) step(10'd0, 1'b0, 1'b1, 3'd7, 4'(k), tag);
  endtask

  // Monitor: pop and compare both instances on every result
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected valid", rd_data_o, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data_o == e, t, rd_data_o, e);
        check(nrw_valid && nrw_data == e[NW-1:0], {t, " narrow"},
              32'(nrw_data), 32'(e[NW-1:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd0);
    finish_run();
  end

  initial begin
    for (int k = 0; k < 10; k++) mdl[k] = 32'd0;
    rst_n = 1'b0; clr_i = 1'b0; evt_i = '0; rd_req_i = 1'b0;
    rd_op_i = '0; rd_idx_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    // R1: reset state
    check(rd_valid_o == 1'b0, "R1 valid after reset", 32'(rd_valid_o), 32'd0);
    read_all("R1 zero after reset");

    // R2 and R4: distinct per-counter counts
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j <= k; j++) step(10'(1 << k), 1'b0, 1'b0, 3'd0, 4'd0, "");
    end
    step(10'h3FF, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h2AA, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h155, 1'b0, 1'b0, 3'd0, 4'd0, "");
    read_all("R2 R4 mapped counts");

    // R8: read coinciding with an event on the selected counter
    step(10'h001, 1'b0, 1'b1, 3'd7, 4'd0, "R8 pre-increment");
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd0, "R8 after increment");
    step(10'h200, 1'b0, 1'b1, 3'd7, 4'd9, "R8 pre-increment idx9");

    // R6: foreign opcodes
    step(10'h000, 1'b0, 1'b1, 3'd6, 4'd0, "R6 opcode 6");
    step(10'h000, 1'b0, 1'b1, 3'd0, 4'd3, "R6 opcode 0");
    // R7: indexes above 9
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd10, "R7 index 10");
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd15, "R7 index 15");

    // R3: back-to-back reads with gaps around them
    idle(2);
    step(10'h0F0, 1'b0, 1'b1, 3'd7, 4'd5, "R3 back-to-back a");
    step(10'h0F0, 1'b0, 1'b1, 3'd7, 4'd6, "R3 back-to-back b");
    step(10'h0F0, 1'b0, 1'b1, 3'd7, 4'd7, "R3 back-to-back c");
    idle(2);
    check(exp_q.size() == 0, "R3 all results returned", 32'(exp_q.size()), 32'd0);

    // R9: clear
    step(10'h000, 1'b1, 1'b0, 3'd0, 4'd0, "");
    read_all("R9 zero after clear");

    // R10: clear against simultaneous events
    step(10'h3FF, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h3FF, 1'b1, 1'b0, 3'd0, 4'd0, "");
    read_all("R10 clear beats event");

    // R5: narrow instance wraps after 2**NW events
    for (int i = 0; i < (1 << NW) - 1; i++) step(10'h002, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd1, "R5 at full scale");
    step(10'h002, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd1, "R5 wrapped to zero");
    step(10'h002, 1'b0, 1'b0, 3'd0, 4'd0, "");
    step(10'h000, 1'b0, 1'b1, 3'd7, 4'd1, "R5 after wrap");

    idle(3);
    check(exp_q.size() == 0, "R3 no missing results", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule